// File: doc/BRIEF.md
# Auto-Reloading Cyclic Transfer Channel

A single transfer channel that walks a table in memory and feeds it to a fixed peripheral register, or fills a table from a fixed register. Each hardware request moves exactly one unit (a byte or a 16-bit word) with one read beat and then one write beat on a simple single-beat bus master port. One endpoint is a memory pointer that steps through the table. The other is a fixed I/O pointer. A programmable transfer count sets how many units make up one pass over the table.

When a pass ends, the channel restores the memory pointer and the count to the values that were last programmed. It raises a one-cycle end-of-pass pulse and keeps running, so a periodic trigger such as a timer match can cycle a pattern out indefinitely. An eight-way source select picks which request line drives the channel. The source also fixes the direction: the serial-receive source moves data into memory, and every other source moves data out of memory. A hold-address variant keeps both pointers still and still counts passes.

Configuration uses a small register port. Select 0 is the memory pointer, select 1 the I/O pointer, select 2 the count and select 3 the control byte. Writing the pointer or the count also updates its reload copy.

Top module: `dmarep_chan`

## Requirements
- R1: Each served request produces exactly one read beat (`bus_we`=0) followed in the next beat by one write beat (`bus_we`=1). Each beat holds `bus_req`, `bus_addr` and `bus_we` until `bus_ack`. The write data equals the read data. Control bit 1 selects word (`bus_size`=1, all 16 bits) or byte (`bus_size`=0, bits 15:8 written as zero).
- R2: When control bits 4:2 equal the receive source (index 5), the read is from the I/O pointer and the write is to the memory pointer. For any other source, the read is from the memory pointer and the write is to the I/O pointer.
- R3: In normal mode the memory pointer moves by 1 (byte) or 2 (word) after each transfer, upward when control bit 7 is 0 and downward when it is 1. The I/O pointer changes only when software writes it.
- R4: With a programmed count N (0 means 256), the Nth transfer restores the memory pointer and the count to their programmed values, and the channel keeps serving requests without being re-enabled.
- R5: `eob` is high for exactly one cycle after each reload. `irq` is high in that same cycle only when control bit 5 is set.
- R6: When control bits 5 and 6 are both set (hold-address mode), neither pointer moves. The count still decrements and reloads.
- R7: A transfer starts only on a rising edge of `trig_in[ctrl[4:2]]` while control bit 0 (run) is set. Edges on other lines, or any edge while run is clear, start no transfer.
- R8: A request that arrives while a transfer is in progress is held and served after the write beat. It is not lost.
- R9: A control write with bit 0 set takes effect only if a control read that returned bit 0 clear came before it, with no control write in between. Otherwise the write is ignored. A control write with bit 0 clear always takes effect.
- R10: After reset, all registers read 0 and `bus_req`, `eob` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_re | input | 1 | Register read strobe (used for control arming) |
| cfg_sel | input | 2 | Register select: 0 memory pointer, 1 I/O pointer, 2 count, 3 control |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data (combinational from select) |
| trig_in | input | 8 | Request lines, one per source |
| bus_req | output | 1 | Beat request |
| bus_we | output | 1 | 1 for write beat, 0 for read beat |
| bus_size | output | 1 | 1 word, 0 byte |
| bus_addr | output | ADDR_W | Beat address |
| bus_wdata | output | 16 | Write beat data |
| bus_rdata | input | 16 | Read beat data |
| bus_ack | input | 1 | Beat completion |
| eob | output | 1 | End-of-pass pulse |
| irq | output | 1 | Interrupt, end-of-pass gated by control bit 5 |

## Verification
The bench runs several patterns, and each one separates a different fault.
- An upward byte table of count 3 driven from an ordinary source shows whether the step size, the reload point and the byte masking are right.
- A downward word table driven from the receive source checks the direction swap and the interrupt gating.
- The hold-address pattern and the count-of-zero pass separate correct pointer freezing and 256-unit wrap from an off-by-one reload.
- Edges on unselected lines, a stalled bus with a second edge, and control writes with and without a prior read show whether requests are filtered, held while busy, and whether the control register stays locked.

// File: rtl/dmarep_pkg.sv
package dmarep_pkg;
   localparam int WORD_W  = 16;
   localparam int SEL_W   = 3;
   localparam int NUM_SRC = 1 << SEL_W;

   typedef enum logic [1:0] {
      RS_MEM  = 2'd0,
      RS_IO   = 2'd1,
      RS_CNT  = 2'd2,
      RS_CTRL = 2'd3
   } regsel_e;

   typedef struct packed {
      logic             step_dn;
      logic             rep_en;
      logic             irq_en;
      logic [SEL_W-1:0] src;
      logic             word;
      logic             run;
   } ctrl_t;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_RD   = 2'd1,
      SQ_WR   = 2'd2
   } sq_e;
endpackage

// File: rtl/dmarep_ctl.sv
module dmarep_ctl
   import dmarep_pkg::*;
#(
   parameter int ADDR_W = 16
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              cfg_re,
   input  logic [1:0]        cfg_sel,
   input  logic [WORD_W-1:0] cfg_wdata,
   output ctrl_t             ctrl,
   output logic [ADDR_W-1:0] io_addr
);
   regsel_e sel;
   logic    armed;
   logic    ctrl_hit;
   logic    ctrl_ok;

   assign sel      = regsel_e'(cfg_sel);
   assign ctrl_hit = cfg_we && (sel == RS_CTRL);
   assign ctrl_ok  = ctrl_hit && (!cfg_wdata[0] || armed);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl    <= '0;
         io_addr <= '0;
         armed   <= 1'b0;
      end else begin
         if (ctrl_ok)
            ctrl <= ctrl_t'(cfg_wdata[$bits(ctrl_t)-1:0]);
         if (ctrl_hit)
            armed <= 1'b0;
         else if (cfg_re && (sel == RS_CTRL) && !ctrl.run)
            armed <= 1'b1;
         if (cfg_we && (sel == RS_IO))
            io_addr <= cfg_wdata[ADDR_W-1:0];
      end
   end

   AST_LOCKED_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_hit && !armed && cfg_wdata[0]) |=> $stable(ctrl))
      else $error("locked control changed"); // R9
   AST_IO_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_we && (sel == RS_IO)) |=> $stable(io_addr))
      else $error("io pointer moved"); // R3
endmodule

// File: rtl/dmarep_req.sv
module dmarep_req
   import dmarep_pkg::*;
#(
   parameter bit TRIG_EDGE = 1'b1
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] trig_in,
   input  logic [SEL_W-1:0]   src,
   input  logic               run,
   input  logic               take,
   output logic               pend
);
   logic hit;

   generate
      if (TRIG_EDGE) begin : g_edge
         logic [NUM_SRC-1:0] trig_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) trig_q <= '0;
            else        trig_q <= trig_in;
         end
         assign hit = trig_in[src] & ~trig_q[src];
      end else begin : g_level
         assign hit = trig_in[src];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    pend <= 1'b0;
      else if (!run) pend <= 1'b0;
      else           pend <= (pend & ~take) | hit;
   end

   AST_PEND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (run && pend && !take) |=> pend)
      else $error("pending request lost"); // R8
endmodule

// File: rtl/dmarep_ring.sv
module dmarep_ring #(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mem_we,
   input  logic              cnt_we,
   input  logic [ADDR_W-1:0] addr_wd,
   input  logic [CNT_W-1:0]  cnt_wd,
   input  logic              done,
   input  logic              word,
   input  logic              step_dn,
   input  logic              hold,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [CNT_W-1:0]  cnt,
   output logic              eob
);
   logic [ADDR_W-1:0] mem_base;
   logic [ADDR_W-1:0] step;
   logic [ADDR_W-1:0] nxt;
   logic [CNT_W-1:0]  cnt_base;
   logic              last;

   assign step = word ? ADDR_W'(2) : ADDR_W'(1);
   assign nxt  = step_dn ? (mem_addr - step) : (mem_addr + step);
   assign last = (cnt == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_addr <= '0;
         mem_base <= '0;
      end else if (mem_we) begin
         mem_addr <= addr_wd;
         mem_base <= addr_wd;
      end else if (done && !hold) begin
         mem_addr <= last ? mem_base : nxt;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         cnt_base <= '0;
      end else if (cnt_we) begin
         cnt      <= cnt_wd;
         cnt_base <= cnt_wd;
      end else if (done) begin
         cnt <= last ? cnt_base : (cnt - CNT_W'(1));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) eob <= 1'b0;
      else        eob <= done && last;
   end

   AST_RELOAD_CNT: assert property (@(posedge clk) disable iff (!rst_n)
      eob |-> (cnt == cnt_base))
      else $error("count not restored"); // R4
   AST_EOB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      eob |=> !eob)
      else $error("end pulse too long"); // R5
   AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && !mem_we) |=> $stable(mem_addr))
      else $error("pointer moved in hold mode"); // R6
endmodule

// File: rtl/dmarep_seq.sv
module dmarep_seq
   import dmarep_pkg::*;
#(
   parameter int ADDR_W = 16
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pend,
   input  logic              run,
   input  logic              to_mem,
   input  logic              word,
   input  logic [ADDR_W-1:0] mem_addr,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              bus_ack,
   input  logic [WORD_W-1:0] bus_rdata,
   output logic              take,
   output logic              done,
   output logic              bus_req,
   output logic              bus_we,
   output logic              bus_size,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [WORD_W-1:0] bus_wdata
);
   sq_e               st;
   logic [ADDR_W-1:0] src_q;
   logic [ADDR_W-1:0] dst_q;
   logic [WORD_W-1:0] data_q;
   logic              size_q;

   assign take = (st == SQ_IDLE) && pend && run;
   assign done = (st == SQ_WR) && bus_ack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= SQ_IDLE;
         src_q  <= '0;
         dst_q  <= '0;
         data_q <= '0;
         size_q <= 1'b0;
      end else begin
         case (st)
            SQ_IDLE: if (take) begin
               src_q  <= to_mem ? io_addr : mem_addr;
               dst_q  <= to_mem ? mem_addr : io_addr;
               size_q <= word;
               st     <= SQ_RD;
            end
            SQ_RD: if (bus_ack) begin
               data_q <= bus_rdata;
               st     <= SQ_WR;
            end
            SQ_WR: if (bus_ack) st <= SQ_IDLE;
            default: st <= SQ_IDLE;
         endcase
      end
   end

   assign bus_req   = (st != SQ_IDLE);
   assign bus_we    = (st == SQ_WR);
   assign bus_size  = size_q;
   assign bus_addr  = (st == SQ_WR) ? dst_q : src_q;
   assign bus_wdata = size_q ? data_q : {8'h00, data_q[7:0]};

   AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)))
      else $error("beat dropped before ack"); // R1
   AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_we && bus_ack) |=> (bus_req && bus_we))
      else $error("read not followed by write"); // R1
   AST_QUIET_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_req && !run) |=> !bus_req)
      else $error("beat started while stopped"); // R7
endmodule

// File: rtl/dmarep_chan.sv
module dmarep_chan
   import dmarep_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int CNT_W     = 8,
   parameter int RX_SRC    = 5,
   parameter bit TRIG_EDGE = 1'b1
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic               cfg_re,
   input  logic [1:0]         cfg_sel,
   input  logic [WORD_W-1:0]  cfg_wdata,
   output logic [WORD_W-1:0]  cfg_rdata,
   input  logic [NUM_SRC-1:0] trig_in,
   output logic               bus_req,
   output logic               bus_we,
   output logic               bus_size,
   output logic [ADDR_W-1:0]  bus_addr,
   output logic [WORD_W-1:0]  bus_wdata,
   input  logic [WORD_W-1:0]  bus_rdata,
   input  logic               bus_ack,
   output logic               eob,
   output logic               irq
);
   generate
      if (ADDR_W < 2 || ADDR_W > WORD_W) begin : g_bad_addr
         $error("ADDR_W must lie in 2..16");
      end
      if (CNT_W < 1 || CNT_W > WORD_W) begin : g_bad_cnt
         $error("CNT_W must lie in 1..16");
      end
      if (RX_SRC < 0 || RX_SRC >= NUM_SRC) begin : g_bad_src
         $error("RX_SRC out of source range");
      end
   endgenerate

   ctrl_t             ctrl;
   regsel_e           sel;
   logic [ADDR_W-1:0] io_addr;
   logic [ADDR_W-1:0] mem_addr;
   logic [CNT_W-1:0]  cnt;
   logic              pend, take, done;
   logic              hold, to_mem;

   assign sel    = regsel_e'(cfg_sel);
   assign hold   = ctrl.irq_en & ctrl.rep_en;
   assign to_mem = (ctrl.src == SEL_W'(RX_SRC));

   dmarep_ctl #(.ADDR_W(ADDR_W)) u_ctl (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_re(cfg_re),
      .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .ctrl(ctrl), .io_addr(io_addr)
   );

   dmarep_req #(.TRIG_EDGE(TRIG_EDGE)) u_req (
      .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .src(ctrl.src),
      .run(ctrl.run), .take(take), .pend(pend)
   );

   dmarep_ring #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ring (
      .clk(clk), .rst_n(rst_n),
      .mem_we(cfg_we && (sel == RS_MEM)), .cnt_we(cfg_we && (sel == RS_CNT)),
      .addr_wd(cfg_wdata[ADDR_W-1:0]), .cnt_wd(cfg_wdata[CNT_W-1:0]),
      .done(done), .word(ctrl.word), .step_dn(ctrl.step_dn), .hold(hold),
      .mem_addr(mem_addr), .cnt(cnt), .eob(eob)
   );

   dmarep_seq #(.ADDR_W(ADDR_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .pend(pend), .run(ctrl.run), .to_mem(to_mem),
      .word(ctrl.word), .mem_addr(mem_addr), .io_addr(io_addr),
      .bus_ack(bus_ack), .bus_rdata(bus_rdata), .take(take), .done(done),
      .bus_req(bus_req), .bus_we(bus_we), .bus_size(bus_size),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata)
   );

   always_comb begin
      case (sel)
         RS_MEM:  cfg_rdata = WORD_W'(mem_addr);
         RS_IO:   cfg_rdata = WORD_W'(io_addr);
         RS_CNT:  cfg_rdata = WORD_W'(cnt);
         default: cfg_rdata = WORD_W'(ctrl);
      endcase
   end

   assign irq = eob & ctrl.irq_en;
endmodule

// File: tb/tb_dmarep_chan.sv
`timescale 1ns/1ps
module tb_dmarep_chan;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0, cfg_re = 1'b0;
   logic [1:0]  cfg_sel = 2'd0;
   logic [15:0] cfg_wdata = 16'h0;
   logic [15:0] cfg_rdata;
   logic [7:0]  trig_in = 8'h0;
   logic        bus_req, bus_we, bus_size, bus_ack, eob, irq;
   logic [15:0] bus_addr, bus_wdata, bus_rdata;
   logic        ack_en = 1'b1;
   int          n_chk = 0, n_err = 0;
   bit          finished = 1'b0;

   always #10 clk = ~clk;

   function automatic logic [15:0] mdl(input logic [15:0] a);
      return {a[7:0] ^ 8'h5A, a[15:8] ^ 8'hC3};
   endfunction

   assign bus_ack   = bus_req & ack_en;
   assign bus_rdata = mdl(bus_addr);

   dmarep_chan dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_re(cfg_re), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .trig_in(trig_in),
      .bus_req(bus_req), .bus_we(bus_we), .bus_size(bus_size), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
      .eob(eob), .irq(irq)
   );

   logic [15:0] rd_a [0:1023];
   logic [15:0] wr_a [0:1023];
   logic [15:0] wr_d [0:1023];
   logic        wr_s [0:1023];
   int rd_n = 0, wr_n = 0, eob_n = 0, irq_n = 0;

   always @(posedge clk) begin
      if (rst_n) begin
         if (bus_req && bus_ack && !bus_we) begin rd_a[rd_n] = bus_addr; rd_n = rd_n + 1; end
         if (bus_req && bus_ack && bus_we) begin
            wr_a[wr_n] = bus_addr; wr_d[wr_n] = bus_wdata; wr_s[wr_n] = bus_size;
            wr_n = wr_n + 1;
         end
         if (eob) eob_n = eob_n + 1;
         if (irq) irq_n = irq_n + 1;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] mk(input bit run, input bit word, input int src,
                                      input bit irqe, input bit rep, input bit dn);
      return {8'h00, dn, rep, irqe, 3'(src), word, run};
   endfunction

   task automatic cfg_wr(input logic [1:0] s, input logic [15:0] d);
      @(negedge clk); cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
      @(negedge clk); cfg_we = 1'b0;
   endtask

   task automatic cfg_rd(input logic [1:0] s, output logic [15:0] d);
      @(negedge clk); cfg_re = 1'b1; cfg_sel = s;
      #1 d = cfg_rdata;
      @(negedge clk); cfg_re = 1'b0;
   endtask

   task automatic set_ctrl(input logic [15:0] v);
      logic [15:0] tmp;
      cfg_rd(2'd3, tmp);
      cfg_wr(2'd3, v);
   endtask

   task automatic pulse(input int idx);
      @(negedge clk); trig_in[idx] = 1'b1;
      @(negedge clk); trig_in[idx] = 1'b0;
      repeat (6) @(negedge clk);
   endtask

   task automatic t_reset;
      logic [15:0] v;
      chk("R10 bus_req", bus_req, 0);
      chk("R10 eob", eob, 0);
      chk("R10 irq", irq, 0);
      for (int s = 0; s < 4; s++) begin
         cfg_rd(2'(s), v);
         chk("R10 register", v, 0);
      end
   endtask

   task automatic t_repeat_byte;
      int r0, w0, e0, i0;
      logic [15:0] v, ra;
      cfg_wr(2'd3, 16'h0);
      cfg_wr(2'd0, 16'h0100); cfg_wr(2'd1, 16'h0040); cfg_wr(2'd2, 16'd3);
      set_ctrl(mk(1, 0, 1, 0, 0, 0));
      r0 = rd_n; w0 = wr_n; e0 = eob_n; i0 = irq_n;
      pulse(1); pulse(1);
      chk("R4 no early reload", eob_n - e0, 0);
      pulse(1);
      chk("R5 one eob at count end", eob_n - e0, 1);
      pulse(1);
      chk("R1 four transfers", wr_n - w0, 4);
      for (int k = 0; k < 4; k++) begin
         ra = 16'h0100 + 16'(k % 3);
         chk("R3 byte step up", rd_a[r0+k], ra);
         chk("R2 write to io", wr_a[w0+k], 16'h0040);
         chk("R1 byte data", wr_d[w0+k], {8'h00, mdl(ra)[7:0]});
         chk("R1 byte size", wr_s[w0+k], 0);
      end
      cfg_rd(2'd0, v); chk("R4 pointer after reload", v, 16'h0101);
      cfg_rd(2'd2, v); chk("R4 count after reload", v, 2);
      cfg_rd(2'd1, v); chk("R3 io fixed", v, 16'h0040);
      chk("R5 irq masked", irq_n - i0, 0);
   endtask

   task automatic t_word_rx;
      int r0, w0, e0, i0;
      logic [15:0] v;
      cfg_wr(2'd3, 16'h0);
      cfg_wr(2'd0, 16'h0200); cfg_wr(2'd1, 16'h0080); cfg_wr(2'd2, 16'd2);
      set_ctrl(mk(1, 1, 5, 1, 0, 1));
      r0 = rd_n; w0 = wr_n; e0 = eob_n; i0 = irq_n;
      pulse(5); pulse(5); pulse(5);
      for (int k = 0; k < 3; k++) begin
         chk("R2 read from io", rd_a[r0+k], 16'h0080);
         chk("R3 word step down", wr_a[w0+k], (k == 1) ? 16'h01FE : 16'h0200);
         chk("R1 word data", wr_d[w0+k], mdl(16'h0080));
         chk("R1 word size", wr_s[w0+k], 1);
      end
      cfg_rd(2'd0, v); chk("R4 pointer", v, 16'h01FE);
      chk("R5 eob", eob_n - e0, 1);
      chk("R5 irq enabled", irq_n - i0, 1);
   endtask

   task automatic t_hold;
      int r0, e0;
      logic [15:0] v;
      cfg_wr(2'd3, 16'h0);
      cfg_wr(2'd0, 16'h0300); cfg_wr(2'd1, 16'h0090); cfg_wr(2'd2, 16'd2);
      set_ctrl(mk(1, 0, 2, 1, 1, 0));
      r0 = rd_n; e0 = eob_n;
      pulse(2); pulse(2); pulse(2);
      chk("R6 three reads", rd_n - r0, 3);
      for (int k = 0; k < 3; k++) chk("R6 pointer frozen", rd_a[r0+k], 16'h0300);
      cfg_rd(2'd0, v); chk("R6 pointer readback", v, 16'h0300);
      cfg_rd(2'd2, v); chk("R6 count still runs", v, 1);
      chk("R6 reload pulse", eob_n - e0, 1);
   endtask

   task automatic t_select;
      int w0;
      w0 = wr_n;
      pulse(0); pulse(3); pulse(5);
      chk("R7 other lines ignored", wr_n - w0, 0);
      cfg_wr(2'd3, mk(0, 0, 2, 1, 1, 0));
      pulse(2);
      chk("R7 stopped channel ignores", wr_n - w0, 0);
      chk("R7 no beat when stopped", bus_req, 0);
   endtask

   task automatic t_pending;
      int r0, w0;
      cfg_wr(2'd3, 16'h0);
      cfg_wr(2'd0, 16'h0500); cfg_wr(2'd1, 16'h0060); cfg_wr(2'd2, 16'd10);
      set_ctrl(mk(1, 1, 4, 0, 0, 0));
      r0 = rd_n; w0 = wr_n;
      ack_en = 1'b0;
      pulse(4);
      chk("R8 stalled beat held", bus_req, 1);
      pulse(4);
      chk("R8 nothing written yet", wr_n - w0, 0);
      @(negedge clk); ack_en = 1'b1;
      repeat (12) @(negedge clk);
      chk("R8 both served", wr_n - w0, 2);
      chk("R8 first read", rd_a[r0], 16'h0500);
      chk("R8 second read", rd_a[r0+1], 16'h0502);
   endtask

   task automatic t_lock;
      logic [15:0] v;
      cfg_wr(2'd3, 16'h0);
      cfg_wr(2'd3, mk(1, 0, 1, 0, 0, 0));
      cfg_rd(2'd3, v); chk("R9 write without read ignored", v, 0);
      cfg_wr(2'd3, mk(1, 0, 1, 0, 0, 0));
      cfg_rd(2'd3, v); chk("R9 armed write taken", v, mk(1, 0, 1, 0, 0, 0));
      cfg_wr(2'd3, mk(1, 1, 3, 0, 0, 0));
      cfg_rd(2'd3, v); chk("R9 read while running does not arm", v, mk(1, 0, 1, 0, 0, 0));
      cfg_wr(2'd3, 16'h0);
      cfg_rd(2'd3, v); chk("R9 stop always taken", v, 0);
   endtask

   task automatic t_count256;
      int e0, i0;
      logic [15:0] v;
      cfg_wr(2'd3, 16'h0);
      cfg_wr(2'd0, 16'h1000); cfg_wr(2'd1, 16'h0020); cfg_wr(2'd2, 16'd0);
      set_ctrl(mk(1, 0, 6, 1, 0, 0));
      e0 = eob_n; i0 = irq_n;
      for (int k = 0; k < 255; k++) pulse(6);
      chk("R4 zero count not yet done at 255", eob_n - e0, 0);
      pulse(6);
      chk("R4 zero count means 256", eob_n - e0, 1);
      chk("R5 irq at 256", irq_n - i0, 1);
      cfg_rd(2'd0, v); chk("R4 pointer restored", v, 16'h1000);
      cfg_rd(2'd2, v); chk("R4 count restored", v, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_repeat_byte();
      t_word_rx();
      t_hold();
      t_select();
      t_pending();
      t_lock();
      t_count256();
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end
endmodule